// File: doc/BRIEF.md
# Real-Time Clock Calendar Counter with Alarm

This block keeps the time of day and the calendar date of a real-time clock. A free-running enable at 32 kHz drives an internal prescaler, and the prescaler produces one update per second. Each update advances seconds, minutes and hours, and then the day of week, day of month, month, year and century as each lower field carries over. Every field is presented to the host as one byte. The encoding of those bytes follows two run-time mode inputs: packed BCD or plain binary, and 24-hour or 12-hour format. In 12-hour format the top bit of the hours byte marks PM.

A host writes any time field through a simple select/data/strobe port. It also writes three alarm bytes for seconds, minutes and hours. After each update the alarm bytes are compared with the new time, and an alarm byte with its top two bits both set matches any value. The block sets an update-ended flag and an alarm flag. It drives an interrupt from whichever of the two flags is enabled. Shortly before each update it raises an update-in-progress indication, so that software knows not to read the time during that window.

A freeze mode stops the time from advancing but still accepts writes. A divider-hold setting stops the prescaler entirely. When the hold is released, the first update arrives after half a second.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the time reads 00:00:00, day of week 1, day of month 1, month 1, year 0, century 20; both flags, the interrupt and the update-in-progress output are 0.
- R2: Each update advances seconds by one. Seconds and minutes wrap from 59 to 0 with a carry, hours wrap from 23 to 0 with a carry, and day of week runs 1 to 7 and wraps back to 1 on each day carry.
- R3: Day of month wraps to 1 after day 30 in months 4, 6, 9 and 11, after day 31 in the other months, and after day 28 in month 2, or day 29 when the binary year is divisible by 4. Month 12 wraps to 1 and increments the year, and year 99 wraps to 0 and increments the century.
- R4: When bin_mode_i is 1, bytes are plain binary. When it is 0, bytes are packed BCD with tens in bits 7:4 and units in bits 3:0. Writes are decoded and reads are encoded with the mode in effect at that moment.
- R5: When h24_i is 0, hours read 1 to 12, midnight reads 12 with bit 7 clear, noon reads 12 with bit 7 set, and bit 7 is set for every PM hour. Writes to hours use the same coding.
- R6: Every update sets upd_flag_o one clock after the time changes. uip_o is 1 for the last UIP_TICKS ticks of each second and 0 otherwise.
- R7: After an update, alm_flag_o is set when each of the three alarm bytes either equals the current encoded byte of its field or has bits 7:6 equal to 11, which marks it as a wildcard.
- R8: While set_mode_i is 1, the time does not advance, no alarm flag is set, and host writes to time fields still take effect.
- R9: While div_sel_i is 110 or 111, no update occurs and uip_o is 0. After a release to any other value, the first update happens TICKS_PER_SEC/2 ticks later.
- R10: flag_ack_i clears both flags, but a flag set in the same cycle wins. irq_o is 1 when upd_flag_o and upd_ie_i are both 1, or when alm_flag_o and alm_ie_i are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 32 kHz enable pulse |
| bin_mode_i | input | 1 | 1 selects binary bytes, 0 selects BCD |
| h24_i | input | 1 | 1 selects 24-hour format, 0 selects 12-hour |
| set_mode_i | input | 1 | Freezes the time and blocks the alarm |
| div_sel_i | input | 3 | Divider select; 110 and 111 hold the prescaler |
| upd_ie_i | input | 1 | Interrupt enable for the update flag |
| alm_ie_i | input | 1 | Interrupt enable for the alarm flag |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 4 | Field select: 0 sec, 1 sec alarm, 2 min, 3 min alarm, 4 hour, 5 hour alarm, 6 day of week, 7 day of month, 8 month, 9 year, 10 century |
| wr_data_i | input | 8 | Write data in the current encoding |
| flag_ack_i | input | 1 | Clears both flags |
| sec_o | output | 8 | Seconds byte |
| min_o | output | 8 | Minutes byte |
| hour_o | output | 8 | Hours byte |
| dow_o | output | 8 | Day-of-week byte |
| dom_o | output | 8 | Day-of-month byte |
| mon_o | output | 8 | Month byte |
| year_o | output | 8 | Year byte |
| cent_o | output | 8 | Century byte |
| uip_o | output | 1 | Update in progress |
| upd_flag_o | output | 1 | Update-ended flag |
| alm_flag_o | output | 1 | Alarm flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Time bytes change at the clock edge that takes the prescaler from its last count to zero. The flags follow one edge later, and a host write shows on the outputs after the edge that captures it. The bench reads outputs on falling edges only. It waits for the update flag instead of counting cycles. After each wait it makes every write and mode change within a few dozen cycles, well inside the second, so that no update falls between stimulus and check. Two checks do depend on exact cycle counts: the width of the update-in-progress window, counted over one full second, and the half-second delay after a divider release, measured as TICKS_PER_SEC/2 plus the one-edge flag latency.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [4:0] hour;
        logic [2:0] dow;
        logic [4:0] dom;
        logic [3:0] mon;
        logic [6:0] year;
        logic [6:0] cent;
    } rtc_time_t;

    typedef enum logic [3:0] {
        SEL_SEC   = 4'd0,
        SEL_ASEC  = 4'd1,
        SEL_MIN   = 4'd2,
        SEL_AMIN  = 4'd3,
        SEL_HOUR  = 4'd4,
        SEL_AHOUR = 4'd5,
        SEL_DOW   = 4'd6,
        SEL_DOM   = 4'd7,
        SEL_MON   = 4'd8,
        SEL_YEAR  = 4'd9,
        SEL_CENT  = 4'd10
    } rtc_sel_e;

    function automatic logic [7:0] to_byte(input logic [6:0] v, input logic bin);
        logic [6:0] tens;
        logic [6:0] ones;
        tens = v / 7'd10;
        ones = v % 7'd10;
        return bin ? {1'b0, v} : {tens[3:0], ones[3:0]};
    endfunction

    function automatic logic [6:0] from_byte(input logic [7:0] d, input logic bin);
        logic [7:0] val;
        val = ({4'd0, d[7:4]} * 8'd10) + {4'd0, d[3:0]};
        return bin ? d[6:0] : val[6:0];
    endfunction

    function automatic logic [7:0] hour_to_byte(input logic [4:0] h, input logic bin,
                                                input logic h24);
        logic [4:0] h12;
        logic [7:0] b;
        if (h == 5'd0)       h12 = 5'd12;
        else if (h > 5'd12)  h12 = h - 5'd12;
        else                 h12 = h;
        b = to_byte({2'b00, h24 ? h : h12}, bin);
        return h24 ? b : {(h >= 5'd12), b[6:0]};
    endfunction

    function automatic logic [4:0] hour_from_byte(input logic [7:0] d, input logic bin,
                                                  input logic h24);
        logic [6:0] v;
        v = from_byte(h24 ? d : {1'b0, d[6:0]}, bin);
        if (!h24) begin
            if (v == 7'd12) v = 7'd0;
            if (d[7])       v = v + 7'd12;
        end
        return v[4:0];
    endfunction

    function automatic logic [4:0] month_days(input logic [3:0] mon, input logic [6:0] year);
        case (mon)
            4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
            4'd2:                    return (year[1:0] == 2'b00) ? 5'd29 : 5'd28;
            default:                 return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_TICKS     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic hold_i,
    output logic sec_pulse_o,
    output logic uip_o
);
    localparam int CW = $clog2(TICKS_PER_SEC);
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
    localparam logic [CW-1:0] HALF = CW'(TICKS_PER_SEC / 2);
    localparam logic [CW-1:0] WIN  = CW'(TICKS_PER_SEC - UIP_TICKS);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d       = cnt_q;
        sec_pulse_o = 1'b0;
        if (hold_i) begin
            cnt_d = HALF;
        end else if (tick_i) begin
            if (cnt_q == LAST) begin
                cnt_d       = '0;
                sec_pulse_o = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    assign uip_o = !hold_i && (cnt_q >= WIN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
    import rtc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       advance_i,
    input  logic       bin_i,
    input  logic       h24_i,
    input  logic       wr_en_i,
    input  logic [3:0] wr_sel_i,
    input  logic [7:0] wr_data_i,
    output rtc_time_t  time_o
);
    rtc_time_t  t_d, t_q;
    logic [4:0] dim;
    logic [6:0] fld;

    always_comb begin
        t_d = t_q;
        dim = month_days(t_q.mon, t_q.year);
        fld = from_byte(wr_data_i, bin_i);
        if (advance_i) begin
            if (t_q.sec >= 7'd59) begin
                t_d.sec = '0;
                if (t_q.min >= 7'd59) begin
                    t_d.min = '0;
                    if (t_q.hour >= 5'd23) begin
                        t_d.hour = '0;
                        t_d.dow  = (t_q.dow >= 3'd7) ? 3'd1 : t_q.dow + 3'd1;
                        if (t_q.dom >= dim) begin
                            t_d.dom = 5'd1;
                            if (t_q.mon >= 4'd12) begin
                                t_d.mon = 4'd1;
                                if (t_q.year >= 7'd99) begin
                                    t_d.year = '0;
                                    t_d.cent = (t_q.cent >= 7'd99) ? 7'd0 : t_q.cent + 7'd1;
                                end else begin
                                    t_d.year = t_q.year + 7'd1;
                                end
                            end else begin
                                t_d.mon = t_q.mon + 4'd1;
                            end
                        end else begin
                            t_d.dom = t_q.dom + 5'd1;
                        end
                    end else begin
                        t_d.hour = t_q.hour + 5'd1;
                    end
                end else begin
                    t_d.min = t_q.min + 7'd1;
                end
            end else begin
                t_d.sec = t_q.sec + 7'd1;
            end
        end
        if (wr_en_i) begin
            case (rtc_sel_e'(wr_sel_i))
                SEL_SEC:  t_d.sec  = fld;
                SEL_MIN:  t_d.min  = fld;
                SEL_HOUR: t_d.hour = hour_from_byte(wr_data_i, bin_i, h24_i);
                SEL_DOW:  t_d.dow  = fld[2:0];
                SEL_DOM:  t_d.dom  = fld[4:0];
                SEL_MON:  t_d.mon  = fld[3:0];
                SEL_YEAR: t_d.year = fld;
                SEL_CENT: t_d.cent = fld;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q      <= '0;
            t_q.dow  <= 3'd1;
            t_q.dom  <= 5'd1;
            t_q.mon  <= 4'd1;
            t_q.cent <= 7'd20;
        end else begin
            t_q <= t_d;
        end
    end

    assign time_o = t_q;
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic [3:0] wr_sel_i,
    input  logic [7:0] wr_data_i,
    input  logic [7:0] cur_sec_i,
    input  logic [7:0] cur_min_i,
    input  logic [7:0] cur_hour_i,
    output logic       match_o
);
    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
    } alarm_t;

    alarm_t a_d, a_q;
    logic [2:0] hit;

    always_comb begin
        a_d = a_q;
        if (wr_en_i) begin
            case (rtc_sel_e'(wr_sel_i))
                SEL_ASEC:  a_d.sec  = wr_data_i;
                SEL_AMIN:  a_d.min  = wr_data_i;
                SEL_AHOUR: a_d.hour = wr_data_i;
                default:   ;
            endcase
        end
        hit[0] = (a_q.sec[7:6]  == 2'b11) || (a_q.sec  == cur_sec_i);
        hit[1] = (a_q.min[7:6]  == 2'b11) || (a_q.min  == cur_min_i);
        hit[2] = (a_q.hour[7:6] == 2'b11) || (a_q.hour == cur_hour_i);
        match_o = &hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_TICKS     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       bin_mode_i,
    input  logic       h24_i,
    input  logic       set_mode_i,
    input  logic [2:0] div_sel_i,
    input  logic       upd_ie_i,
    input  logic       alm_ie_i,
    input  logic       wr_en_i,
    input  logic [3:0] wr_sel_i,
    input  logic [7:0] wr_data_i,
    input  logic       flag_ack_i,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] dow_o,
    output logic [7:0] dom_o,
    output logic [7:0] mon_o,
    output logic [7:0] year_o,
    output logic [7:0] cent_o,
    output logic       uip_o,
    output logic       upd_flag_o,
    output logic       alm_flag_o,
    output logic       irq_o
);
    typedef struct packed {
        logic upd;
        logic alm_ok;
        logic uf;
        logic af;
    } flag_t;

    flag_t     f_d, f_q;
    rtc_time_t time_q;
    logic      div_hold, sec_pulse, alarm_hit;

    assign div_hold = (div_sel_i == 3'b110) || (div_sel_i == 3'b111);

    rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC), .UIP_TICKS(UIP_TICKS)) u_presc (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .hold_i(div_hold),
        .sec_pulse_o(sec_pulse), .uip_o(uip_o)
    );

    rtc_timekeeper u_time (
        .clk(clk), .rst_n(rst_n), .advance_i(sec_pulse && !set_mode_i),
        .bin_i(bin_mode_i), .h24_i(h24_i), .wr_en_i(wr_en_i),
        .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .time_o(time_q)
    );

    assign sec_o  = to_byte(time_q.sec, bin_mode_i);
    assign min_o  = to_byte(time_q.min, bin_mode_i);
    assign hour_o = hour_to_byte(time_q.hour, bin_mode_i, h24_i);
    assign dow_o  = to_byte({4'd0, time_q.dow}, bin_mode_i);
    assign dom_o  = to_byte({2'd0, time_q.dom}, bin_mode_i);
    assign mon_o  = to_byte({3'd0, time_q.mon}, bin_mode_i);
    assign year_o = to_byte(time_q.year, bin_mode_i);
    assign cent_o = to_byte(time_q.cent, bin_mode_i);

    rtc_alarm_match u_alarm (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
        .wr_data_i(wr_data_i), .cur_sec_i(sec_o), .cur_min_i(min_o),
        .cur_hour_i(hour_o), .match_o(alarm_hit)
    );

    always_comb begin
        f_d        = f_q;
        f_d.upd    = sec_pulse;
        f_d.alm_ok = !set_mode_i;
        if (flag_ack_i) begin
            f_d.uf = 1'b0;
            f_d.af = 1'b0;
        end
        if (f_q.upd) begin
            f_d.uf = 1'b1;
            if (f_q.alm_ok && alarm_hit) f_d.af = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign upd_flag_o = f_q.uf;
    assign alm_flag_o = f_q.af;
    assign irq_o      = (f_q.uf && upd_ie_i) || (f_q.af && alm_ie_i);
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
    import rtc_cal_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic                          set_mode,
    input logic                          hold,
    input logic                          wr_en,
    input logic                          sec_pulse,
    input logic                          upd_pend,
    input logic                          ack,
    input logic                          uip,
    input logic                          uf,
    input logic                          af,
    input logic [$bits(rtc_time_t)-1:0]  time_bits
);
    a_r8_set_freezes_time: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mode && !wr_en) |=> $stable(time_bits));

    a_r9_hold_freezes_time: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !wr_en) |=> $stable(time_bits));

    a_r6_uip_before_update: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |-> uip);

    a_r6_uip_done_at_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uf) |-> !uip);

    a_r7_alarm_with_update: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(af) |-> uf);

    a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !upd_pend) |=> (!uf && !af));
endmodule

bind rtc_calendar_core rtc_calendar_chk u_chk (
    .clk(clk), .rst_n(rst_n), .set_mode(set_mode_i), .hold(div_hold),
    .wr_en(wr_en_i), .sec_pulse(sec_pulse), .upd_pend(f_q.upd),
    .ack(flag_ack_i), .uip(uip_o), .uf(upd_flag_o), .af(alm_flag_o),
    .time_bits(time_q)
);

// File: tb/rtc_calendar_core_tb.sv
module rtc_calendar_core_tb;
    localparam int TPS = 64;
    localparam int UIPT = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic bin_mode = 1'b0, h24 = 1'b1, set_mode = 1'b0;
    logic [2:0] div_sel = 3'b010;
    logic upd_ie = 1'b0, alm_ie = 1'b0;
    logic wr_en = 1'b0;
    logic [3:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic flag_ack = 1'b0;
    logic [7:0] sec, min, hour, dow, dom, mon, year, cent;
    logic uip, uf, af, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rtc_calendar_core #(.TICKS_PER_SEC(TPS), .UIP_TICKS(UIPT)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .bin_mode_i(bin_mode), .h24_i(h24),
        .set_mode_i(set_mode), .div_sel_i(div_sel), .upd_ie_i(upd_ie), .alm_ie_i(alm_ie),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data), .flag_ack_i(flag_ack),
        .sec_o(sec), .min_o(min), .hour_o(hour), .dow_o(dow), .dom_o(dom), .mon_o(mon),
        .year_o(year), .cent_o(cent), .uip_o(uip), .upd_flag_o(uf), .alm_flag_o(af),
        .irq_o(irq)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        flag_ack = 1'b1;
        repeat (3) @(negedge clk);
        flag_ack = 1'b0;
    endtask

    task automatic wait_upd();
        int n;
        ack();
        n = 0;
        while (!uf && n < 300) begin
            @(negedge clk);
            n++;
        end
        if (!uf) begin
            n_chk++; n_fail++;
            $display("FAIL R6: no update flag, got 0 expected 1");
        end
    endtask

    task automatic load(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                        input logic [7:0] dw, input logic [7:0] dm, input logic [7:0] mo,
                        input logic [7:0] y, input logic [7:0] c);
        wr(4'd4, h); wr(4'd2, m); wr(4'd0, s); wr(4'd6, dw);
        wr(4'd7, dm); wr(4'd8, mo); wr(4'd9, y); wr(4'd10, c);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 sec", sec, 8'h00);  check("R1 min", min, 8'h00);
        check("R1 hour", hour, 8'h00); check("R1 dow", dow, 8'h01);
        check("R1 dom", dom, 8'h01);  check("R1 mon", mon, 8'h01);
        check("R1 year", year, 8'h00); check("R1 cent", cent, 8'h20);
        check("R1 flags", {5'd0, uf, af, irq}, 8'h00);
        check("R1 uip", {7'd0, uip}, 8'h00);
    endtask

    task automatic t_rollover();
        wait_upd();
        load(8'h23, 8'h59, 8'h59, 8'h07, 8'h31, 8'h12, 8'h99, 8'h20);
        wait_upd();
        check("R2 sec", sec, 8'h00);  check("R2 min", min, 8'h00);
        check("R2 hour", hour, 8'h00); check("R2 dow", dow, 8'h01);
        check("R3 dom", dom, 8'h01);  check("R3 mon", mon, 8'h01);
        check("R3 year", year, 8'h00); check("R3 cent", cent, 8'h21);
        wait_upd();
        check("R2 sec step", sec, 8'h01);
    endtask

    task automatic t_months();
        wait_upd();
        load(8'h23, 8'h59, 8'h59, 8'h03, 8'h28, 8'h02, 8'h24, 8'h20);
        wait_upd();
        check("R3 leap feb dom", dom, 8'h29); check("R3 leap feb mon", mon, 8'h02);
        wait_upd();
        load(8'h23, 8'h59, 8'h59, 8'h03, 8'h28, 8'h02, 8'h23, 8'h20);
        wait_upd();
        check("R3 feb dom", dom, 8'h01); check("R3 feb mon", mon, 8'h03);
        wait_upd();
        load(8'h23, 8'h59, 8'h59, 8'h03, 8'h30, 8'h04, 8'h23, 8'h20);
        wait_upd();
        check("R3 apr dom", dom, 8'h01); check("R3 apr mon", mon, 8'h05);
        wait_upd();
        load(8'h23, 8'h59, 8'h59, 8'h03, 8'h30, 8'h05, 8'h23, 8'h20);
        wait_upd();
        check("R3 may dom", dom, 8'h31); check("R3 may mon", mon, 8'h05);
    endtask

    task automatic t_binary();
        wait_upd();
        bin_mode = 1'b1;
        wr(4'd4, 8'h05); wr(4'd2, 8'h0A); wr(4'd0, 8'h3B);
        wait_upd();
        check("R4 bin sec", sec, 8'h00); check("R4 bin min", min, 8'h0B);
        check("R4 bin hour", hour, 8'h05);
        @(negedge clk);
        bin_mode = 1'b0;
        @(negedge clk);
        check("R4 bcd min", min, 8'h11); check("R4 bcd hour", hour, 8'h05);
    endtask

    task automatic t_12h();
        wait_upd();
        h24 = 1'b0;
        wr(4'd4, 8'h91); wr(4'd2, 8'h59); wr(4'd0, 8'h59);
        @(negedge clk);
        check("R5 11pm", hour, 8'h91);
        wait_upd();
        check("R5 midnight", hour, 8'h12);
        wait_upd();
        wr(4'd4, 8'h11); wr(4'd2, 8'h59); wr(4'd0, 8'h59);
        wait_upd();
        check("R5 noon", hour, 8'h92);
        h24 = 1'b1;
        @(negedge clk);
        check("R5 back to 24h", hour, 8'h12);
    endtask

    task automatic t_uip();
        int hi;
        wait_upd();
        check("R6 flag set", {7'd0, uf}, 8'h01);
        check("R6 uip low after update", {7'd0, uip}, 8'h00);
        hi = 0;
        for (int i = 0; i < TPS; i++) begin
            @(negedge clk);
            if (uip) hi++;
        end
        check("R6 uip width", 8'(hi), 8'(UIPT));
    endtask

    task automatic t_alarm();
        wait_upd();
        wr(4'd0, 8'h10); wr(4'd1, 8'h11); wr(4'd3, 8'hC0); wr(4'd5, 8'hFF);
        alm_ie = 1'b1;
        wait_upd();
        check("R7 sec", sec, 8'h11);
        check("R7 wildcard hit", {7'd0, af}, 8'h01);
        check("R10 irq alarm", {7'd0, irq}, 8'h01);
        wr(4'd2, 8'h00); wr(4'd3, 8'h05); wr(4'd1, 8'h12);
        wait_upd();
        check("R7 sec2", sec, 8'h12);
        check("R7 minute mismatch", {7'd0, af}, 8'h00);
        alm_ie = 1'b0;
    endtask

    task automatic t_set();
        wait_upd();
        wr(4'd1, 8'hC0); wr(4'd3, 8'hC0); wr(4'd5, 8'hC0);
        set_mode = 1'b1;
        wr(4'd0, 8'h45);
        check("R8 write accepted", sec, 8'h45);
        ack();
        repeat (2 * TPS) @(negedge clk);
        check("R8 frozen", sec, 8'h45);
        check("R8 no alarm", {7'd0, af}, 8'h00);
        check("R8 update flag", {7'd0, uf}, 8'h01);
        set_mode = 1'b0;
        wait_upd();
        check("R8 resume", sec, 8'h46);
    endtask

    task automatic t_divider();
        logic [7:0] s0;
        int n;
        wait_upd();
        div_sel = 3'b110;
        s0 = sec;
        repeat (3 * TPS) @(negedge clk);
        check("R9 held", sec, s0);
        check("R9 uip off", {7'd0, uip}, 8'h00);
        ack();
        @(negedge clk);
        check("R9 no flag", {7'd0, uf}, 8'h00);
        div_sel = 3'b010;
        n = 0;
        while (!uf && n < 300) begin
            @(negedge clk);
            n++;
        end
        check("R9 half second", 8'(n), 8'(TPS / 2 + 1));
        check("R9 one step", sec, s0 + 8'h01);
    endtask

    task automatic t_irq();
        upd_ie = 1'b1;
        wait_upd();
        check("R10 irq update", {7'd0, irq}, 8'h01);
        ack();
        check("R10 ack clears", {6'd0, uf, irq}, 8'h00);
        upd_ie = 1'b0;
        wait_upd();
        check("R10 masked", {6'd0, uf, irq}, 8'h02);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rollover();
        t_months();
        t_binary();
        t_12h();
        t_uip();
        t_alarm();
        t_set();
        t_divider();
        t_irq();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule